// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits next to a small 8-bit processor core and runs the fixed-length hardware sequences that carry the core into an interrupt handler and back out of it. When the global interrupt enable is set, a request is pending, the core is at an instruction boundary and the one-instruction window after enabling has closed, the block takes the lowest-numbered request. It acknowledges that source, clears the global enable, and writes the three-byte return address to a downward-growing stack. It then hands the core the handler's vector address. While a sequence runs, `hold_o` is high and the core must stall.

A return strobe starts the mirror sequence. Three bytes are read back, high byte first, from a stack memory with one cycle of read latency. The program counter is reloaded with the reassembled address, and the global enable is set again. If the core is asleep when an interrupt is taken, the block first waits for the external wake-up-complete signal, then adds a fixed five-cycle wake penalty, and then runs the normal entry. The jump held in the vector slot is fetched and executed by the core, not by this block.

The stack interface is a plain memory port with no back-pressure. A write lands at the clock edge that ends the cycle in which `stk_we_o` is high. Read data for a cycle with `stk_re_o` high must be on `stk_rdata_i` in the following cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `gie_o` is 0, `sp_o` equals SP_INIT (default 0x04FF), `hold_o` is 0, and `ack_o`, `stk_we_o`, `stk_re_o` and `pc_load_o` are all 0.
- R2: A one-cycle `sei_i` sets `gie_o` from the next cycle and `cli_i` clears it. While `gie_o` is 0, pending requests produce no `ack_o` and `hold_o` stays 0.
- R3: When several bits of `irq_req_i` are set, the lowest bit index is served. `ack_o` is high for exactly one cycle, the first entry cycle, with `ack_id_o` equal to that index.
- R4: In entry cycles 0, 1 and 2, `stk_we_o` is high at addresses SP, SP-1 and SP-2 with data PC[7:0], PC[15:8] and PC[23:16], where SP and PC are the values at acceptance. `sp_o` drops by one after each write and ends at SP-3. Stack writes and reads are never both high.
- R5: An entry lasts five cycles with `hold_o` high. `pc_load_o` is high only in entry cycle 4, with `pc_load_addr_o` equal to twice the vector index. The core's program counter therefore holds the vector five edges after acceptance.
- R6: `gie_o` is 0 from the cycle after entry cycle 0 until software or a return sets it.
- R7: While `insn_busy_i` is high, no request is accepted. Acceptance happens at the first edge with `insn_busy_i` low.
- R8: After `sei_i`, no request is accepted before the next `insn_retire_i` pulse. The first acceptance can come at the edge after that pulse.
- R9: If `sleep_i` is high at acceptance, `hold_o` rises and the block waits for `wake_done_i`. After the edge that samples it, five further cycles pass with `ack_o` low before entry cycle 0.
- R10: A `reti_i` pulse in idle starts a five-cycle return. In cycles 0, 1 and 2, `stk_re_o` is high at addresses SP+1, SP+2 and SP+3, returning the high, middle and low byte, and `sp_o` rises by one after each read. In cycle 4, `pc_load_o` carries the reassembled address. From the next cycle `gie_o` is 1 and `sp_o` is SP+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | NUM_IRQ | Pending request flags, bit index is the vector number |
| ack_o | output | 1 | One-cycle acknowledge to the served source |
| ack_id_o | output | IDW | Index of the served request |
| insn_busy_i | input | 1 | Core is inside a multi-cycle instruction |
| insn_retire_i | input | 1 | An instruction completes this cycle |
| sei_i | input | 1 | Set global enable (instruction retiring) |
| cli_i | input | 1 | Clear global enable |
| sleep_i | input | 1 | Core is in sleep |
| wake_done_i | input | 1 | Oscillator start-up after wake has finished |
| reti_i | input | 1 | Return-from-interrupt strobe |
| pc_i | input | PC_W | Return address to save on entry |
| pc_load_o | output | 1 | Load program counter this cycle |
| pc_load_addr_o | output | PC_W | Value to load into the program counter |
| hold_o | output | 1 | Sequence in progress, core must stall |
| gie_o | output | 1 | Global interrupt enable |
| sp_o | output | SP_W | Stack pointer |
| stk_we_o | output | 1 | Stack write strobe |
| stk_re_o | output | 1 | Stack read strobe |
| stk_addr_o | output | SP_W | Stack byte address |
| stk_wdata_o | output | 8 | Stack write data |
| stk_rdata_i | input | 8 | Stack read data, one cycle after the read strobe |

## Verification
The assertions assume that the core does not pulse `sei_i`, `cli_i` or `reti_i` while `hold_o` is high. They also assume that the stack memory returns read data exactly one cycle after `stk_re_o`. Under those conditions, an acknowledge always coincides with a cleared enable on the next cycle, and a return always sets it. The bench keeps within these assumptions. Its stack memory model has a fixed one-cycle read, and it drives the enable, disable and return strobes only in idle cycles. Each source keeps its request flag asserted until it sees its acknowledge, and every request is removed before a return, so a handler is never re-entered by accident.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_WAKE  = 3'd1,
    SEQ_WEXT  = 3'd2,
    SEQ_ENTER = 3'd3,
    SEQ_RET   = 3'd4
  } seq_state_e;

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_IRQ = 8,
  parameter int IDW     = 3
) (
  input  logic [NUM_IRQ-1:0] req_i,
  output logic               any_o,
  output logic [IDW-1:0]     id_o,
  output logic [NUM_IRQ-1:0] grant_o
);

  // seen[i] is high when any request below index i is pending
  logic [NUM_IRQ:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chain
    assign seen[i+1]  = seen[i] | req_i[i];
    assign grant_o[i] = req_i[i] & ~seen[i];
  end

  assign any_o = seen[NUM_IRQ];

  always_comb begin
    id_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grant_o[i]) id_o = id_o | IDW'(i);
    end
  end

endmodule

// File: rtl/irq_gie.sv
module irq_gie (
  input  logic clk,
  input  logic rst_n,
  input  logic sei_i,
  input  logic cli_i,
  input  logic retire_i,
  input  logic entry_clr_i,
  input  logic ret_set_i,
  output logic gie_o,
  output logic shadow_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_o    <= 1'b0;
      shadow_o <= 1'b0;
    end else begin
      if (entry_clr_i)    gie_o <= 1'b0;
      else if (ret_set_i) gie_o <= 1'b1;
      else if (sei_i)     gie_o <= 1'b1;
      else if (cli_i)     gie_o <= 1'b0;

      // the instruction after the enabling one must retire first
      if (sei_i)         shadow_o <= 1'b1;
      else if (retire_i) shadow_o <= 1'b0;
    end
  end

  assert_entry_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_clr_i |=> !gie_o);

  assert_ret_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_set_i |=> gie_o);

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int PC_W       = 24,
  parameter int SP_W       = 16,
  parameter logic [SP_W-1:0] SP_INIT = 16'h04FF,
  parameter int WAKE_EXTRA = 5,
  localparam int IDW       = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  output logic               ack_o,
  output logic [IDW-1:0]     ack_id_o,
  input  logic               insn_busy_i,
  input  logic               insn_retire_i,
  input  logic               sei_i,
  input  logic               cli_i,
  input  logic               sleep_i,
  input  logic               wake_done_i,
  input  logic               reti_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic               pc_load_o,
  output logic [PC_W-1:0]    pc_load_addr_o,
  output logic               hold_o,
  output logic               gie_o,
  output logic [SP_W-1:0]    sp_o,
  output logic               stk_we_o,
  output logic               stk_re_o,
  output logic [SP_W-1:0]    stk_addr_o,
  output logic [7:0]         stk_wdata_o,
  input  logic [7:0]         stk_rdata_i
);

  localparam int PC_BYTES = PC_W / 8;
  localparam int SEQ_LEN  = PC_BYTES + 2;
  localparam int CNT_MAX  = (SEQ_LEN > WAKE_EXTRA) ? SEQ_LEN : WAKE_EXTRA;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int BW       = (PC_BYTES > 1) ? $clog2(PC_BYTES) : 1;
  localparam logic [CNT_W-1:0] SEQ_LAST  = CNT_W'(SEQ_LEN - 1);
  localparam logic [CNT_W-1:0] WEXT_LAST = CNT_W'(WAKE_EXTRA - 1);
  localparam logic [CNT_W-1:0] XFER_N    = CNT_W'(PC_BYTES);

  seq_state_e          state;
  logic [CNT_W-1:0]    cnt;
  logic [IDW-1:0]      vec_q;
  logic [PC_W-1:0]     pc_q;
  logic [PC_W-1:0]     ret_pc;
  logic [SP_W-1:0]     sp_q;
  logic                rd_pend;
  logic [BW-1:0]       rd_idx;
  logic [BW-1:0]       rd_byte;

  logic                any_req;
  logic [IDW-1:0]      pick_id;
  logic [NUM_IRQ-1:0]  grant;
  logic                shadow;
  logic                accept;
  logic                in_enter;
  logic                in_ret;
  logic                xfer;

  irq_pick #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_pick (
    .req_i   (irq_req_i),
    .any_o   (any_req),
    .id_o    (pick_id),
    .grant_o (grant)
  );

  irq_gie u_gie (
    .clk         (clk),
    .rst_n       (rst_n),
    .sei_i       (sei_i),
    .cli_i       (cli_i),
    .retire_i    (insn_retire_i),
    .entry_clr_i (ack_o),
    .ret_set_i   (pc_load_o && in_ret),
    .gie_o       (gie_o),
    .shadow_o    (shadow)
  );

  assign accept   = gie_o && any_req && !insn_busy_i && !shadow;
  assign in_enter = (state == SEQ_ENTER);
  assign in_ret   = (state == SEQ_RET);
  assign xfer     = (cnt < XFER_N);
  assign rd_byte  = BW'(PC_BYTES - 1) - cnt[BW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      cnt     <= '0;
      vec_q   <= '0;
      pc_q    <= '0;
      ret_pc  <= '0;
      sp_q    <= SP_INIT;
      rd_pend <= 1'b0;
      rd_idx  <= '0;
    end else begin
      rd_pend <= stk_re_o;
      rd_idx  <= rd_byte;
      for (int i = 0; i < PC_BYTES; i++) begin
        if (rd_pend && rd_idx == BW'(i)) ret_pc[8*i +: 8] <= stk_rdata_i;
      end

      unique case (state)
        SEQ_IDLE: begin
          cnt <= '0;
          if (reti_i) begin
            state <= SEQ_RET;
          end else if (accept) begin
            vec_q <= pick_id;
            pc_q  <= pc_i;
            state <= sleep_i ? SEQ_WAKE : SEQ_ENTER;
          end
        end
        SEQ_WAKE: begin
          if (wake_done_i) begin
            state <= SEQ_WEXT;
            cnt   <= '0;
          end
        end
        SEQ_WEXT: begin
          if (cnt == WEXT_LAST) begin
            state <= SEQ_ENTER;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_ENTER: begin
          if (xfer) sp_q <= sp_q - 1'b1;
          if (cnt == SEQ_LAST) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_RET: begin
          if (xfer) sp_q <= sp_q + 1'b1;
          if (cnt == SEQ_LAST) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    stk_wdata_o = '0;
    for (int i = 0; i < PC_BYTES; i++) begin
      if (cnt == CNT_W'(i)) stk_wdata_o = pc_q[8*i +: 8];
    end
  end

  assign ack_o          = in_enter && (cnt == '0);
  assign ack_id_o       = vec_q;
  assign stk_we_o       = in_enter && xfer;
  assign stk_re_o       = in_ret && xfer;
  assign stk_addr_o     = in_enter ? sp_q : sp_q + 1'b1;
  assign pc_load_o      = (in_enter || in_ret) && (cnt == SEQ_LAST);
  assign pc_load_addr_o = in_enter ? PC_W'({vec_q, 1'b0}) : ret_pc;
  assign hold_o         = (state != SEQ_IDLE);
  assign sp_o           = sp_q;

  assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we_o |=> sp_o == $past(sp_o) - SP_W'(1));

  assert_no_rw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_we_o && stk_re_o));

  assert_load_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |=> !hold_o);

  assert_pop_inc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_re_o |=> sp_o == $past(sp_o) + SP_W'(1));

endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_req_i = '0;
  logic        ack_o;
  logic [2:0]  ack_id_o;
  logic        insn_busy_i = 1'b0;
  logic        insn_retire_i = 1'b0;
  logic        sei_i = 1'b0;
  logic        cli_i = 1'b0;
  logic        sleep_i = 1'b0;
  logic        wake_done_i = 1'b0;
  logic        reti_i = 1'b0;
  logic [23:0] pc_i = '0;
  logic        pc_load_o;
  logic [23:0] pc_load_addr_o;
  logic        hold_o;
  logic        gie_o;
  logic [15:0] sp_o;
  logic        stk_we_o;
  logic        stk_re_o;
  logic [15:0] stk_addr_o;
  logic [7:0]  stk_wdata_o;
  logic [7:0]  stk_rdata_i = '0;

  logic [7:0]  mem [0:1023];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [15:0] exp_sp = 16'h04FF;

  always #10 clk = ~clk;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .ack_o(ack_o),
    .ack_id_o(ack_id_o), .insn_busy_i(insn_busy_i), .insn_retire_i(insn_retire_i),
    .sei_i(sei_i), .cli_i(cli_i), .sleep_i(sleep_i), .wake_done_i(wake_done_i),
    .reti_i(reti_i), .pc_i(pc_i), .pc_load_o(pc_load_o),
    .pc_load_addr_o(pc_load_addr_o), .hold_o(hold_o), .gie_o(gie_o), .sp_o(sp_o),
    .stk_we_o(stk_we_o), .stk_re_o(stk_re_o), .stk_addr_o(stk_addr_o),
    .stk_wdata_o(stk_wdata_o), .stk_rdata_i(stk_rdata_i)
  );

  always @(posedge clk) begin
    if (stk_we_o) mem[stk_addr_o[9:0]] <= stk_wdata_o;
    if (stk_re_o) stk_rdata_i <= mem[stk_addr_o[9:0]];
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int lowest(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return 0;
  endfunction

  // starts in entry cycle 0
  task automatic entry_cycles(input logic [23:0] pc, input int vec);
    for (int k = 0; k < 5; k++) begin
      check("R3", "ack", ack_o, k == 0);
      if (k == 0) begin
        check("R3", "ack_id", ack_id_o, vec);
        irq_req_i[vec] = 1'b0;
      end
      check("R5", "hold", hold_o, 1);
      check("R4", "we", stk_we_o, k < 3);
      check("R4", "sp", sp_o, exp_sp);
      if (k < 3) begin
        check("R4", "push addr", stk_addr_o, exp_sp);
        check("R4", "push data", stk_wdata_o, pc[8*k +: 8]);
        exp_sp = exp_sp - 16'd1;
      end
      check("R5", "pc_load", pc_load_o, k == 4);
      if (k == 4) check("R5", "vector", pc_load_addr_o, vec * 2);
      step();
    end
    check("R5", "hold end", hold_o, 0);
    check("R6", "gie cleared", gie_o, 0);
    check("R4", "sp after", sp_o, exp_sp);
  endtask

  task automatic do_entry(input logic [23:0] pc, input logic [7:0] mask);
    irq_req_i = mask;
    pc_i = pc;
    step();
    entry_cycles(pc, lowest(mask));
  endtask

  task automatic do_return(input logic [23:0] pc);
    irq_req_i = '0;
    reti_i = 1'b1;
    step();
    reti_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check("R10", "re", stk_re_o, k < 3);
      if (k < 3) begin
        check("R10", "pop addr", stk_addr_o, exp_sp + 16'd1);
        exp_sp = exp_sp + 16'd1;
      end
      check("R10", "pc_load", pc_load_o, k == 4);
      if (k == 4) check("R10", "ret pc", pc_load_addr_o, pc);
      step();
    end
    check("R10", "gie set", gie_o, 1);
    check("R10", "sp after", sp_o, exp_sp);
    check("R10", "hold end", hold_o, 0);
  endtask

  task automatic enable_gie();
    sei_i = 1'b1; insn_retire_i = 1'b1;
    step();
    sei_i = 1'b0;
    step();
    insn_retire_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    logic [23:0] pa, pb;
    logic [7:0]  ma, mb;
    void'($urandom(32'h1234_5678));
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1", "gie", gie_o, 0);
    check("R1", "sp", sp_o, 16'h04FF);
    check("R1", "hold", hold_o, 0);
    check("R1", "strobes", {ack_o, stk_we_o, stk_re_o, pc_load_o}, 0);

    // R2 requests ignored with enable low
    irq_req_i = 8'h24;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R2", "ack while disabled", ack_o, 0);
      check("R2", "hold while disabled", hold_o, 0);
    end

    // R8 enable shadow: no acceptance until next retire
    sei_i = 1'b1; insn_retire_i = 1'b1;
    step();
    sei_i = 1'b0; insn_retire_i = 1'b0;
    check("R2", "gie after sei", gie_o, 1);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R8", "hold in shadow", hold_o, 0);
    end
    insn_retire_i = 1'b1;
    step();
    insn_retire_i = 1'b0;
    check("R8", "hold at retire+1", hold_o, 0);
    pa = 24'h12_3456;
    do_entry(pa, 8'h24);
    do_return(pa);

    // R2 cli clears
    cli_i = 1'b1;
    step();
    cli_i = 1'b0;
    check("R2", "gie after cli", gie_o, 0);
    irq_req_i = 8'h01;
    step();
    check("R2", "no ack after cli", hold_o, 0);
    irq_req_i = '0;
    enable_gie();

    // R7 busy defers acceptance
    insn_busy_i = 1'b1;
    irq_req_i = 8'h80;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R7", "hold while busy", hold_o, 0);
    end
    insn_busy_i = 1'b0;
    pa = 24'hAB_CDEF;
    do_entry(pa, 8'h80);
    do_return(pa);

    // R9 wake from sleep
    sleep_i = 1'b1;
    pa = 24'h0F_1E2D;
    pc_i = pa;
    irq_req_i = 8'h0A;
    step();
    for (int k = 0; k < 4; k++) begin
      check("R9", "hold while waking", hold_o, 1);
      check("R9", "ack while waking", ack_o, 0);
      step();
    end
    wake_done_i = 1'b1; sleep_i = 1'b0;
    step();
    wake_done_i = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check("R9", "ack in wake penalty", ack_o, 0);
      check("R9", "hold in wake penalty", hold_o, 1);
      step();
    end
    entry_cycles(pa, 1);
    do_return(pa);

    // random entries, some nested, with busy delays (R3 R4 R5 R10)
    for (int it = 0; it < 40; it++) begin
      ma = 8'($urandom());
      if (ma == 0) ma = 8'h40;
      pa = 24'($urandom());
      if ($urandom_range(0, 1) == 1) begin
        insn_busy_i = 1'b1;
        irq_req_i = ma;
        for (int k = 0; k < int'($urandom_range(1, 3)); k++) begin
          step();
          check("R7", "hold while busy", hold_o, 0);
        end
        insn_busy_i = 1'b0;
      end
      do_entry(pa, ma);
      if ($urandom_range(0, 2) == 0) begin
        irq_req_i = '0;
        enable_gie();
        mb = 8'($urandom()) | 8'h10;
        pb = 24'($urandom());
        do_entry(pb, mb);
        do_return(pb);
        irq_req_i = '0;
        cli_i = 1'b1;
        step();
        cli_i = 1'b0;
      end
      do_return(pa);
    end
    finish_run();
  end

endmodule